// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a two-wire serial bus in front of a 2048-byte memory. The memory is split into eight blocks of 256 bytes. The block samples SCL and SDA with the system clock and finds START and STOP. It decodes the first byte of each transfer as a control byte. From there it runs single-byte writes, random reads and current-address reads, and sequential reads that carry on from one byte to the next. SDA is an open-drain line. The block drives it only through an output enable: a high enable pulls the line low.

The three bits below the control code in the control byte are not a device address. They supply the top three bits of the memory address. A STOP that ends a successful write starts an internal programming interval whose length is set by a parameter. For the whole of that interval the slave acknowledges nothing, and this includes a control byte that matches. A master can use this silence to poll for the end of the interval.

Top module: `eep_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins reception of a control byte from any state. A STOP (SDA rises while SCL is high) returns the block to idle. Either one releases SDA (sda_oe_o = 0) at once, even in the middle of a byte, and a STOP that cuts off a write before its data byte starts no programming interval.
- R2: The control byte is sent MSB first. If its bits [7:4] equal 1010 binary, the slave sets sda_oe_o to 1 for the ninth clock. For any other code it never drives SDA until the next START.
- R3: Control byte bits [3:1] become bits [10:8] of the internal 11-bit address. Bit [0] selects a read when 1 and a write when 0.
- R4: In a write, the second byte is acknowledged and becomes address bits [7:0]. The third byte is acknowledged and stored at that address when its acknowledge clock ends, and the address then advances by one. Any further byte in the same transfer is not acknowledged and is not stored.
- R5: A STOP that follows a stored byte starts a busy interval of BUSY_CYCLES clocks. During that interval no byte is acknowledged, not even a matching control byte, and no memory write occurs.
- R6: Once the busy interval has expired, a matching control byte is acknowledged normally.
- R7: In a read, the byte at the current address is shifted out MSB first with sda_oe_o equal to the inverse of each bit. The enable changes only after SCL falls. SDA is released during the master's acknowledge clock.
- R8: If the master acknowledges a read byte, the address advances by one (2047 wraps to 0) and the next byte follows. If the master does not acknowledge, SDA stays released until a STOP or START, and the address does not advance.
- R9: sda_oe_o holds steady throughout every SCL high period, except where a START or STOP has just occurred.
- R10: While rst_n is low and straight after it, sda_oe_o is 0, the block is idle and it is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, sampling both bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The output enable changes on the third clock edge after an SCL edge reaches the pins: two synchronizer stages and then the output register. The bench compares the enable against its model on every clock from the fifth clock of each SCL low phase to the end of the following high phase, and pauses the comparison around each SCL fall and around each START and STOP. The busy interval begins a few clocks after the STOP is seen. A control byte sent straight after a STOP is decided about 150 clocks later, well inside a 400-clock interval. The recovery attempt waits 600 clocks, so neither result sits near the boundary where the counter expires.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA,
      ST_HOLD
   } eep_state_t;

   localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("eep_line_sync: SYNC_STAGES must lie in 1..4");
   end

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scl_s <= 1'b1;
            sda_s <= 1'b1;
         end else begin
            scl_s <= scl_i;
            sda_s <= sda_i;
         end
      end
   end else begin : g_chain
      logic [SYNC_STAGES-2:0] scl_m, sda_m;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            {scl_s, scl_m} <= '1;
            {sda_s, sda_m} <= '1;
         end else begin
            {scl_s, scl_m} <= {scl_m, scl_i};
            {sda_s, sda_m} <= {sda_m, sda_i};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
   parameter int CYCLES = 1000,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   output logic          busy,
   output logic [CW-1:0] left
);
   if (CYCLES < 1) begin : g_bad_len
      $error("eep_busy_timer: CYCLES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          left <= '0;
      else if (load)       left <= CW'(CYCLES);
      else if (left != '0) left <= left - CW'(1);
   end

   assign busy = (left != '0);
endmodule

// File: rtl/eep_byte_mem.sv
module eep_byte_mem #(
   parameter int AW = 11,
   parameter int DW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/eep_slave.sv
module eep_slave
   import eep_pkg::*;
#(
   parameter int BLK_BITS    = 3,
   parameter int BUSY_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o
);
   localparam int WORD_BITS = 8;
   localparam int AW        = BLK_BITS + WORD_BITS;
   localparam int CW        = $clog2(BUSY_CYCLES + 1);

   if (BLK_BITS < 1 || BLK_BITS > 3) begin : g_bad_blk
      $error("eep_slave: BLK_BITS must lie in 1..3 to fit the control byte");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, busy_load, wr_en, ctrl_decide;
   logic [CW-1:0] busy_left;

   eep_state_t st;
   logic [3:0]    cnt;
   logic          in_ack, rw, wr_pend;
   logic [7:0]    shreg, tx, rd_data;
   logic [AW-1:0] addr;

   eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   eep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .load(busy_load), .busy(busy), .left(busy_left)
   );

   eep_byte_mem #(.AW(AW), .DW(8)) u_mem (
      .clk(clk), .we(wr_en), .waddr(addr), .wdata(shreg),
      .raddr(addr), .rdata(rd_data)
   );

   assign busy_load   = stop_det & wr_pend;
   assign wr_en       = (st == ST_WDATA) & in_ack & scl_fall;
   assign ctrl_decide = (st == ST_CTRL) & scl_fall & ~in_ack & (cnt == 4'd8);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         in_ack   <= 1'b0;
         rw       <= 1'b0;
         wr_pend  <= 1'b0;
         shreg    <= '0;
         tx       <= '0;
         addr     <= '0;
         sda_oe_o <= 1'b0;
      end else if (start_det || stop_det) begin
         st       <= start_det ? ST_CTRL : ST_IDLE;
         cnt      <= '0;
         in_ack   <= 1'b0;
         wr_pend  <= 1'b0;
         sda_oe_o <= 1'b0;
      end else begin
         case (st)
            ST_CTRL, ST_ADDR, ST_WDATA: begin
               if (scl_rise && !in_ack && cnt != 4'd8) begin
                  shreg <= {shreg[6:0], sda_s};
                  cnt   <= cnt + 4'd1;
               end else if (ctrl_decide) begin
                  if (shreg[7:4] == CTRL_CODE && !busy) begin
                     in_ack   <= 1'b1;
                     sda_oe_o <= 1'b1;
                     addr[AW-1:WORD_BITS] <= shreg[BLK_BITS:1];
                     rw       <= shreg[0];
                  end else begin
                     st <= ST_HOLD;
                  end
               end else if (scl_fall && !in_ack && cnt == 4'd8) begin
                  in_ack   <= 1'b1;
                  sda_oe_o <= 1'b1;
                  if (st == ST_ADDR) addr[WORD_BITS-1:0] <= shreg;
               end else if (scl_fall && in_ack) begin
                  in_ack   <= 1'b0;
                  cnt      <= '0;
                  sda_oe_o <= 1'b0;
                  case (st)
                     ST_CTRL: begin
                        if (rw) begin
                           st       <= ST_RDATA;
                           tx       <= rd_data;
                           sda_oe_o <= ~rd_data[7];
                        end else begin
                           st <= ST_ADDR;
                        end
                     end
                     ST_ADDR: st <= ST_WDATA;
                     default: begin
                        addr    <= addr + AW'(1);
                        wr_pend <= 1'b1;
                        st      <= ST_HOLD;
                     end
                  endcase
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  if (!in_ack)   cnt  <= cnt + 4'd1;
                  else if (sda_s) st  <= ST_HOLD;
                  else           addr <= addr + AW'(1);
               end else if (scl_fall) begin
                  if (in_ack) begin
                     in_ack   <= 1'b0;
                     cnt      <= '0;
                     tx       <= rd_data;
                     sda_oe_o <= ~rd_data[7];
                  end else if (cnt == 4'd8) begin
                     in_ack   <= 1'b1;
                     sda_oe_o <= 1'b0;
                  end else begin
                     sda_oe_o <= ~tx[~cnt[2:0]];
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk #(
   parameter int BUSY_CYCLES = 1000,
   parameter int CW          = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_s,
   input logic          start_det,
   input logic          stop_det,
   input logic          sda_oe_o,
   input logic          busy,
   input logic [CW-1:0] busy_left,
   input logic          wr_en,
   input logic          ctrl_decide
);
   // R5: a control byte judged while busy is never acknowledged
   assert_busy_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_decide && busy) |=> !sda_oe_o);

   // R5: memory is not written inside the busy interval
   assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !busy);

   // R5: the remaining count never exceeds the programmed length
   assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(busy_left) <= BUSY_CYCLES);

   // R1: START or STOP releases the line on the next clock
   assert_release_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_oe_o);

   // R7: outside START/STOP, the enable changes only with SCL low
   assert_change_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_oe_o != $past(sda_oe_o)) && !$past(start_det || stop_det)) |-> !scl_s);

   // R9: enable is steady while SCL stays high
   assert_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det || stop_det)) |-> $stable(sda_oe_o));
endmodule

bind eep_slave eep_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe_o(sda_oe_o), .busy(busy),
   .busy_left(busy_left), .wr_en(wr_en), .ctrl_decide(ctrl_decide)
);

// File: tb/eep_slave_tb.sv
`timescale 1ns/1ps
module eep_slave_tb;
   localparam int BUSY = 400;
   localparam int HP   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   eep_slave #(.BLK_BITS(3), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int busy_end = 0;
   bit done = 0;
   bit win = 0;
   logic exp_oe = 1'b0;
   string cur_req = "R10";

   logic [7:0] ref_mem [0:2047];
   int ref_addr = 0;
   bit ref_pend = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // per-clock comparison against the bus-level model
   always @(negedge clk) begin
      if (win && !done) begin
         total++;
         if (sda_oe !== exp_oe) begin
            bad++;
            $display("FAIL %s: sda_oe act=%b exp=%b at cycle %0d", cur_req, sda_oe, exp_oe, cyc);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_bit(input logic m_sda, input logic exp, input string req);
      idle(2);
      sda_m = m_sda;
      exp_oe = exp;
      cur_req = req;
      idle(3);
      win = 1;
      idle(HP - 5);
      scl = 1'b1;
      idle(HP);
      win = 0;
      scl = 1'b0;
   endtask

   task automatic do_start(input string req);
      win = 0;
      if (scl == 1'b0) begin
         idle(2);
         sda_m = 1'b1;
         idle(HP);
         scl = 1'b1;
      end else begin
         sda_m = 1'b1;
      end
      idle(HP);
      sda_m = 1'b0;
      idle(HP);
      chk(sda_oe == 1'b0, req, "sda_oe after START", sda_oe, 0);
      scl = 1'b0;
   endtask

   task automatic do_stop(input string req);
      win = 0;
      idle(2);
      sda_m = 1'b0;
      idle(HP);
      scl = 1'b1;
      idle(HP);
      sda_m = 1'b1;
      idle(HP);
      chk(sda_oe == 1'b0, req, "sda_oe after STOP", sda_oe, 0);
      if (ref_pend) busy_end = cyc + BUSY;
      ref_pend = 0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
      for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, req);
      bus_bit(1'b1, exp_ack, req);
   endtask

   // control byte: [7:4]=1010, [3:1]=block, [0]=1 read
   task automatic send_ctrl(input int blk, input bit rd, input string req);
      logic ack;
      ack = (cyc >= busy_end);
      send_byte({4'b1010, 3'(blk), rd}, ack, req);
      if (ack) ref_addr = (blk << 8) | (ref_addr & 8'hFF);
   endtask

   task automatic rd_byte(input bit mack, input string req);
      logic [7:0] e;
      e = ref_mem[ref_addr];
      for (int i = 7; i >= 0; i--) bus_bit(1'b1, ~e[i], req);
      bus_bit(~mack, 1'b0, req);
      if (mack) ref_addr = (ref_addr + 1) % 2048;
   endtask

   task automatic write_txn(input int a, input logic [7:0] d, input string req);
      do_start(req);
      send_ctrl(a >> 8, 1'b0, req);
      send_byte(8'(a), 1'b1, req);
      ref_addr = a;
      send_byte(d, 1'b1, req);
      ref_mem[ref_addr] = d;
      ref_addr = (ref_addr + 1) % 2048;
      ref_pend = 1;
   endtask

   task automatic rand_read_start(input int a, input string req);
      do_start(req);
      send_ctrl(a >> 8, 1'b0, req);
      send_byte(8'(a), 1'b1, req);
      ref_addr = a;
      do_start(req);
      send_ctrl(a >> 8, 1'b1, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not end act=%0d exp=%0d", cyc, 0);
         finish_up();
      end
   end

   initial begin
      idle(6);
      chk(sda_oe == 1'b0, "R10", "sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      idle(6);
      chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
      scl = 1'b1;

      // R4: single-byte write at 0x310, then R5: poll while busy
      write_txn(11'h310, 8'hA5, "R4");
      do_stop("R4");
      do_start("R5");
      chk(cyc < busy_end, "R5", "model busy at poll", cyc, busy_end);
      send_ctrl(3, 1'b1, "R5");
      send_byte(8'h00, 1'b0, "R5");
      do_stop("R5");
      idle(600);

      // R6/R7/R8: random read after busy expires, master NACK
      rand_read_start(11'h310, "R6");
      rd_byte(1'b0, "R7");
      do_stop("R8");

      // R4: extra data byte is refused; R3: blocks are distinct
      write_txn(11'h010, 8'h3C, "R4");
      send_byte(8'h77, 1'b0, "R4");
      do_stop("R4");
      idle(600);
      rand_read_start(11'h010, "R3");
      rd_byte(1'b0, "R3");
      do_stop("R3");
      rand_read_start(11'h310, "R3");
      rd_byte(1'b0, "R3");
      do_stop("R3");

      // R8: sequential read wraps 2047 -> 0, NACK keeps address
      write_txn(11'h7FF, 8'h81, "R8");
      do_stop("R8");
      idle(600);
      write_txn(11'h000, 8'h42, "R8");
      do_stop("R8");
      idle(600);
      rand_read_start(11'h7FF, "R8");
      rd_byte(1'b1, "R8");
      rd_byte(1'b0, "R8");
      do_stop("R8");
      do_start("R8");
      send_ctrl(0, 1'b1, "R8");
      rd_byte(1'b0, "R8");
      do_stop("R8");

      // R4: address advances after a write (current-address read)
      write_txn(11'h124, 8'h55, "R4");
      do_stop("R4");
      idle(600);
      write_txn(11'h123, 8'h99, "R4");
      do_stop("R4");
      idle(600);
      do_start("R4");
      send_ctrl(1, 1'b1, "R4");
      rd_byte(1'b0, "R4");
      do_stop("R4");

      // R2: wrong control code gets no acknowledge and line stays free
      do_start("R2");
      send_byte(8'b1011_0110, 1'b0, "R2");
      send_byte(8'h10, 1'b0, "R2");
      do_stop("R2");

      // R1: STOP in mid-byte aborts, no busy interval follows
      do_start("R1");
      send_ctrl(2, 1'b0, "R1");
      for (int i = 0; i < 4; i++) bus_bit(1'b1, 1'b0, "R1");
      do_stop("R1");
      do_start("R1");
      send_ctrl(2, 1'b0, "R1");
      do_stop("R1");
      chk(cyc >= busy_end, "R1", "model idle after abort", cyc, busy_end);

      idle(20);
      finish_up();
   end
endmodule